// File: doc/BRIEF.md
# Serial Memory Write-Protection Guard

This block sits beside the command decoder of a small serial memory. It owns the status byte and decides whether each write may go ahead. It holds the write-enable latch, a lock bit that works together with a protect input pin, and a two-bit code that fences off the top quarter, the top half or the whole of the array. Array write requests get a same-cycle grant. A status-register write is taken as pending while chip select is active, and it commits only when chip select is released.

The array size is a parameter, either 4096 or 8192 bytes, and it sets the width of the address input. Serial shifting, opcode decoding, the storage array and the write timing engine are not part of this block. The engine reports only a busy flag. All inputs and outputs are plain level or pulse control signals. No data stream crosses the block edge, so there is no valid/ready handshake and no back-pressure.

Top module: `nvm_wr_guard`

## Requirements
- R1: After reset the status byte reads 0x00 while the engine is idle, and both grants are low.
- R2: Status byte encoding: bit 7 is the lock-enable bit, bits 6 to 4 always read 0, bits 3:2 are the protect code, bit 1 is the write-enable latch, and bit 0 is the busy flag.
- R3: A `wel_set` pulse sets the write-enable latch and a `wel_clr` pulse clears it. When both arrive in the same cycle, the clear wins.
- R4: While the write-enable latch is 0, neither grant is ever asserted.
- R5: `arr_wr_grant` is `arr_wr_req` qualified by latch=1, not busy, and an address outside the fenced range. The fenced range depends on the code. Code 00 fences nothing. Code 01 fences addresses with the two top address bits both 1. Code 10 fences addresses with the top address bit 1. Code 11 fences every address.
- R6: With the latch at 1, a status write is accepted when the lock-enable bit is 0 or `prot_pin` is high. It is refused when the lock-enable bit is 1 and `prot_pin` is low.
- R7: An accepted status write commits on the first clock edge that sees `sel_active` low after being high. `stat_wr_grant` then pulses high for exactly one cycle. Only bits 7, 3 and 2 take the new data.
- R8: If the lock condition (lock-enable bit 1 and `prot_pin` low) arises while a status write is pending, that write is cancelled. After a commit, `prot_pin` has no effect on the stored value.
- R9: While `eng_busy` is high, status bit 0 reads 1 and both grants are withheld.
- R10: The write-enable latch clears on the cycle after `eng_busy` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| prot_pin | input | 1 | Write-protect pin, high permits status writes |
| sel_active | input | 1 | Chip select active (high = selected) |
| stat_wr_req | input | 1 | Status write strobe |
| stat_wr_data | input | 8 | Status write data byte |
| arr_wr_req | input | 1 | Array write request |
| arr_wr_addr | input | ADDR_W | Array byte address (13 bits for 8 KB) |
| eng_busy | input | 1 | Internal write engine busy |
| wel_set | input | 1 | Write-enable set pulse |
| wel_clr | input | 1 | Write-enable clear pulse |
| status_q | output | 8 | Status byte for read-back |
| stat_wr_grant | output | 1 | One-cycle pulse when a status write commits |
| arr_wr_grant | output | 1 | Array write permitted this cycle |

## Verification
The assertions rely on two properties of the inputs. `stat_wr_req` arrives only while `sel_active` is high, and `eng_busy` rises only after a grant has been given, so a drop in busy marks a finished write. The directed stimulus honours both. It raises the status strobe only inside a chip-select window. It drives busy only as a standalone pulse, and no commit lands in the same cycle as that pulse. Every input change is made on the falling clock edge, so each value the design samples is stable for a full cycle.

// File: rtl/nvm_guard_pkg.sv
package nvm_guard_pkg;
  typedef enum logic [1:0] {
    FENCE_NONE    = 2'b00,
    FENCE_QUARTER = 2'b01,
    FENCE_HALF    = 2'b10,
    FENCE_ALL     = 2'b11
  } fence_code_e;

  localparam int LOCK_BIT  = 7;
  localparam int CODE_HI   = 3;
  localparam int CODE_LO   = 2;
  localparam int LATCH_BIT = 1;
  localparam int BUSY_BIT  = 0;
endpackage

// File: rtl/nvm_guard_range.sv
module nvm_guard_range
  import nvm_guard_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  logic [ADDR_W-1:0] addr,
  input  fence_code_e       code,
  output logic              fenced
);
  localparam int TOP = ADDR_W - 1;

  logic top_quarter;
  logic top_half;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign top_quarter = addr[TOP] & addr[TOP-1];
    end else begin : g_narrow
      assign top_quarter = addr[TOP];
    end
  endgenerate

  assign top_half = addr[TOP];

  always_comb begin
    unique case (code)
      FENCE_NONE:    fenced = 1'b0;
      FENCE_QUARTER: fenced = top_quarter;
      FENCE_HALF:    fenced = top_half;
      default:       fenced = 1'b1;
    endcase
  end
endmodule

// File: rtl/nvm_guard_status.sv
module nvm_guard_status
  import nvm_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        prot_pin,
  input  logic        sel_active,
  input  logic        wr_req,
  input  logic [7:0]  wr_data,
  input  logic        busy,
  input  logic        wel_set,
  input  logic        wel_clr,
  output logic        lock_en,
  output fence_code_e code,
  output logic        wel,
  output logic        grant
);
  logic       sel_q;
  logic       busy_q;
  logic       pend;
  logic       pend_lock;
  logic [1:0] pend_code;
  logic       locked;
  logic       allow;
  logic       release_edge;
  logic       busy_done;
  logic       unused_bits;

  assign unused_bits  = ^{wr_data[6:4], wr_data[1:0]};
  assign locked       = lock_en & ~prot_pin;
  assign allow        = wel & ~busy & ~locked;
  assign release_edge = sel_q & ~sel_active;
  assign busy_done    = busy_q & ~busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      sel_q  <= sel_active;
      busy_q <= busy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  wel <= 1'b0;
    else if (wel_clr || busy_done) wel <= 1'b0;
    else if (wel_set)            wel <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_lock <= 1'b0;
      pend_code <= 2'b00;
      lock_en   <= 1'b0;
      code      <= FENCE_NONE;
      grant     <= 1'b0;
    end else begin
      grant <= 1'b0;
      if (release_edge) begin
        if (pend && allow) begin
          lock_en <= pend_lock;
          code    <= fence_code_e'(pend_code);
          grant   <= 1'b1;
        end
        pend <= 1'b0;
      end else if (pend && locked) begin
        pend <= 1'b0;
      end else if (wr_req && sel_active && allow) begin
        pend      <= 1'b1;
        pend_lock <= wr_data[LOCK_BIT];
        pend_code <= wr_data[CODE_HI:CODE_LO];
      end
    end
  end
endmodule

// File: rtl/nvm_wr_guard.sv
module nvm_wr_guard
  import nvm_guard_pkg::*;
#(
  parameter int ARRAY_BYTES = 8192,
  localparam int ADDR_W = $clog2(ARRAY_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prot_pin,
  input  logic              sel_active,
  input  logic              stat_wr_req,
  input  logic [7:0]        stat_wr_data,
  input  logic              arr_wr_req,
  input  logic [ADDR_W-1:0] arr_wr_addr,
  input  logic              eng_busy,
  input  logic              wel_set,
  input  logic              wel_clr,
  output logic [7:0]        status_q,
  output logic              stat_wr_grant,
  output logic              arr_wr_grant
);
  logic        lock_en;
  fence_code_e code;
  logic        wel;
  logic        fenced;

  nvm_guard_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .prot_pin (prot_pin),
    .sel_active(sel_active),
    .wr_req   (stat_wr_req),
    .wr_data  (stat_wr_data),
    .busy     (eng_busy),
    .wel_set  (wel_set),
    .wel_clr  (wel_clr),
    .lock_en  (lock_en),
    .code     (code),
    .wel      (wel),
    .grant    (stat_wr_grant)
  );

  nvm_guard_range #(.ADDR_W(ADDR_W)) u_range (
    .addr   (arr_wr_addr),
    .code   (code),
    .fenced (fenced)
  );

  assign arr_wr_grant = arr_wr_req & wel & ~eng_busy & ~fenced;
  assign status_q     = {lock_en, 3'b000, code, wel, eng_busy};
endmodule

// File: rtl/nvm_wr_guard_chk.sv
module nvm_wr_guard_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_active,
  input logic       eng_busy,
  input logic [7:0] status_q,
  input logic       stat_wr_grant,
  input logic       arr_wr_grant
);
  // R2
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_q[6:4] == 3'b000);

  // R4
  latch_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_wr_grant |-> status_q[1]);

  // R7
  grant_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_grant |=> !stat_wr_grant);

  // R7
  grant_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr_grant |-> !$past(sel_active));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_busy |-> (!arr_wr_grant && status_q[0]));

  // R10
  latch_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_busy) |=> !status_q[1]);
endmodule

bind nvm_wr_guard nvm_wr_guard_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .sel_active   (sel_active),
  .eng_busy     (eng_busy),
  .status_q     (status_q),
  .stat_wr_grant(stat_wr_grant),
  .arr_wr_grant (arr_wr_grant)
);

// File: tb/nvm_wr_guard_tb.sv
module nvm_wr_guard_tb;
  localparam int ARRAY_BYTES = 8192;
  localparam int AW = $clog2(ARRAY_BYTES);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          prot_pin = 1'b1, sel_active = 1'b0, stat_wr_req = 1'b0;
  logic [7:0]    stat_wr_data = 8'h00;
  logic          arr_wr_req = 1'b0, eng_busy = 1'b0, wel_set = 1'b0, wel_clr = 1'b0;
  logic [AW-1:0] arr_wr_addr = '0;
  logic [7:0]    status_q;
  logic          stat_wr_grant, arr_wr_grant;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  nvm_wr_guard #(.ARRAY_BYTES(ARRAY_BYTES)) u_dut (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_set();
    @(negedge clk) wel_set = 1'b1;
    @(negedge clk) wel_set = 1'b0;
  endtask

  task automatic pulse_clr();
    @(negedge clk) wel_clr = 1'b1;
    @(negedge clk) wel_clr = 1'b0;
  endtask

  // Selects, strobes data, optionally drops prot_pin while pending, releases; returns grant.
  task automatic stat_write(input logic [7:0] d, input bit drop_pin, output logic g);
    @(negedge clk) begin sel_active = 1'b1; stat_wr_req = 1'b1; stat_wr_data = d; end
    @(negedge clk) stat_wr_req = 1'b0;
    if (drop_pin) begin
      prot_pin = 1'b0;
      @(negedge clk) prot_pin = 1'b1;
    end
    sel_active = 1'b0;
    @(negedge clk) g = stat_wr_grant;
  endtask

  function automatic logic exp_arr(input logic [1:0] c, input int a, input logic wel, input logic busy);
    logic f;
    case (c)
      2'b00: f = 1'b0;
      2'b01: f = (a >= ARRAY_BYTES * 3 / 4);
      2'b10: f = (a >= ARRAY_BYTES / 2);
      default: f = 1'b1;
    endcase
    return wel & ~busy & ~f;
  endfunction

  task automatic t_reset();
    check("R1 status", status_q, 8'h00);
    check("R1 stat grant", stat_wr_grant, 1'b0);
    arr_wr_req = 1'b1; #1;
    check("R1 arr grant", arr_wr_grant, 1'b0);
    arr_wr_req = 1'b0;
  endtask

  task automatic t_latch();
    logic g;
    stat_write(8'h00, 0, g);
    check("R4 status write refused with latch 0", g, 1'b0);
    pulse_set();
    check("R3 latch set", status_q[1], 1'b1);
    pulse_clr();
    check("R3 latch clear", status_q[1], 1'b0);
    pulse_set();
    @(negedge clk) begin wel_set = 1'b1; wel_clr = 1'b1; end
    @(negedge clk) begin wel_set = 1'b0; wel_clr = 1'b0; end
    check("R3 clear wins", status_q[1], 1'b0);
    @(negedge clk) begin arr_wr_req = 1'b1; arr_wr_addr = '0; end
    #1 check("R4 array refused with latch 0", arr_wr_grant, 1'b0);
    arr_wr_req = 1'b0;
  endtask

  task automatic t_fence();
    logic g;
    int addrs[6] = '{0, 4095, 4096, 6143, 6144, 8191};
    pulse_set();
    for (int c = 0; c < 4; c++) begin
      stat_write({6'b0, 2'(c)} << 2, 0, g);
      check("R7 code write grant", g, 1'b1);
      check("R2 code field", status_q, {4'b0000, 2'(c), 2'b10});
      for (int i = 0; i < 6; i++) begin
        @(negedge clk) begin arr_wr_req = 1'b1; arr_wr_addr = AW'(addrs[i]); end
        #1 check($sformatf("R5 code %0d addr %0h", c, addrs[i]), arr_wr_grant,
                 exp_arr(2'(c), addrs[i], 1'b1, 1'b0));
      end
      arr_wr_req = 1'b0;
    end
  endtask

  task automatic t_perm();
    logic g;
    stat_write(8'hFF, 0, g);
    check("R6 lock 0 pin high grant", g, 1'b1);
    check("R7 only bits 7,3,2 stored", status_q, 8'h8E);
    prot_pin = 1'b0;
    stat_write(8'h00, 0, g);
    check("R6 locked refused", g, 1'b0);
    check("R6 locked unchanged", status_q, 8'h8E);
    prot_pin = 1'b1;
    stat_write(8'h84, 0, g);
    check("R6 lock 1 pin high grant", g, 1'b1);
    check("R6 new value", status_q, 8'h86);
    prot_pin = 1'b0;
    stat_write(8'h00, 0, g);
    check("R6 refused again", g, 1'b0);
    prot_pin = 1'b1;
    stat_write(8'h00, 0, g);
    check("R6 unlock via pin high", status_q, 8'h02);
    prot_pin = 1'b0;
    stat_write(8'h08, 0, g);
    check("R6 lock 0 pin low grant", g, 1'b1);
    check("R6 lock 0 pin low value", status_q, 8'h0A);
    prot_pin = 1'b1;
  endtask

  task automatic t_cancel();
    logic g;
    stat_write(8'h80, 0, g);
    check("R8 setup", status_q, 8'h82);
    stat_write(8'h0C, 1, g);
    check("R8 cancelled grant", g, 1'b0);
    check("R8 cancelled value", status_q, 8'h82);
    stat_write(8'h88, 0, g);
    @(negedge clk) prot_pin = 1'b0;
    @(negedge clk) check("R8 pin after commit no effect", status_q, 8'h8A);
    prot_pin = 1'b1;
    stat_write(8'h00, 0, g);
    check("R8 restore", status_q, 8'h02);
  endtask

  task automatic t_busy();
    logic g;
    @(negedge clk) begin eng_busy = 1'b1; arr_wr_req = 1'b1; arr_wr_addr = '0; end
    #1 check("R9 busy flag", status_q, 8'h03);
    check("R9 array withheld", arr_wr_grant, 1'b0);
    arr_wr_req = 1'b0;
    stat_write(8'h04, 0, g);
    check("R9 status withheld", g, 1'b0);
    @(negedge clk) eng_busy = 1'b0;
    @(negedge clk) check("R10 latch cleared", status_q, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_latch();
    t_fence();
    t_perm();
    t_cancel();
    t_busy();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule